// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Controller

This block runs the open-ended stepping phase of a serial-controlled multi-channel potentiometer. Once the command unit has acknowledged a step command, it pulses `step_arm` with the target channel on `arm_chan`. From then on, every rising edge of the serial clock moves that channel's wiper code by one position. The serial front end reports each rising edge as the one-cycle pulse `scl_rise`. The direction comes from the serial data level at that edge: high counts up, low counts down. The phase has no byte framing and no acknowledge. It lasts until the front end reports a stop or a repeated start.

Each step is issued as a one-cycle write strobe carrying the channel and the new code. The register file that holds the volatile wiper codes absorbs that strobe. The block reads the current codes through a flat bus and never touches any stored (nonvolatile) register. After every step, a settle flag stays raised for a fixed number of clock cycles. This bounds the time in which the analog wiper must reach its new tap.

The controller is a three-state machine:
- `S_IDLE`: not in a step phase.
- `S_ARMED`: in a step phase, waiting for a serial clock edge.
- `S_COMMIT`: the cycle in which the write strobe is presented.

Its transitions are:
- arm, `S_IDLE` to `S_ARMED`, on `step_arm`.
- step, `S_ARMED` to `S_COMMIT`, on `scl_rise`.
- rearm, `S_ARMED` or `S_COMMIT` back to `S_ARMED`, on `step_arm` or after a commit.
- terminate, any state to `S_IDLE`, on `bus_stop` or `bus_start`.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset, `wr_en` and `settle_busy` are 0, and the block is outside the step phase.
- R2: In the step phase, a `scl_rise` pulse with `sda_lvl`=1 at the clock edge E gives `wr_en`=1 for exactly the one cycle after E. In that cycle, `wr_chan` is the armed channel and `wr_code` is the channel's current code plus one.
- R3: In the step phase, a `scl_rise` pulse with `sda_lvl`=0 gives the same single-cycle strobe, with `wr_code` equal to the current code minus one.
- R4: Codes saturate with no wraparound. Stepping up from all-ones writes all-ones, and stepping down from zero writes zero.
- R5: A `scl_rise` pulse produces no strobe before the step phase has been armed. It also produces no strobe in the same cycle as `step_arm`, because the phase starts after the arm.
- R6: A `bus_stop` pulse ends the step phase, and later `scl_rise` pulses produce no strobe.
- R7: A `bus_start` pulse also ends the step phase, with the same effect as R6.
- R8: Any number of up and down steps may be mixed within one phase. Each pulse moves the code by exactly one position, subject to R4.
- R9: `settle_busy` rises in the cycle after each strobe and stays high for exactly SETTLE_CYC cycles. A new step restarts this full window.
- R10: The channel is captured at `step_arm`. Changing `arm_chan` later, without a new arm, does not change the channel written.
- R11: When `scl_rise` coincides with `bus_stop` or `bus_start`, the termination wins and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_arm | input | 1 | One-cycle pulse: step command acknowledged, enter the step phase |
| arm_chan | input | CHW | Target channel, sampled with `step_arm` |
| scl_rise | input | 1 | One-cycle pulse on each synchronised serial clock rising edge |
| sda_lvl | input | 1 | Synchronised serial data level (1 = up, 0 = down) |
| bus_start | input | 1 | One-cycle pulse on a detected start condition |
| bus_stop | input | 1 | One-cycle pulse on a detected stop condition |
| wiper_all | input | NCH*CW | Current wiper codes, channel i at bits [i*CW +: CW] |
| wr_en | output | 1 | One-cycle write strobe to the wiper register file |
| wr_chan | output | CHW | Channel written by the strobe |
| wr_code | output | CW | New wiper code for the strobe |
| settle_busy | output | 1 | High while the wiper settle window is running |

## Verification
The bench builds the block with four channels, 8-bit codes and SETTLE_CYC = 5. The channels start at distinct preset codes (10h, 80h, FEh, 01h). Because two of those presets sit one step from each end, both saturation limits are reached within two pulses. The short settle window lets the bench count the full busy period, and a mid-window restart, in a few cycles. Every channel index is reachable, so the capture of the armed channel against a later change of `arm_chan` can be shown.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARMED  = 2'd1,
        S_COMMIT = 2'd2
    } step_state_e;
endpackage

// File: rtl/wsc_chan_mux.sv
module wsc_chan_mux #(
    parameter int NCH = 4,
    parameter int CW  = 8,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH*CW-1:0] codes_flat,
    input  logic [SELW-1:0]   sel,
    output logic [CW-1:0]     code
);
    logic [CW-1:0] lane [NCH];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_lane
            assign lane[g] = codes_flat[g*CW +: CW];
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == SELW'(i)) code = lane[i];
        end
    end
endmodule

// File: rtl/wsc_sat_step.sv
module wsc_sat_step #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cur,
    input  logic          up,
    output logic [CW-1:0] nxt
);
    localparam logic [CW-1:0] CODE_TOP = '1;
    localparam logic [CW-1:0] CODE_BOT = '0;

    always_comb begin
        if (up) nxt = (cur == CODE_TOP) ? CODE_TOP : cur + 1'b1;
        else    nxt = (cur == CODE_BOT) ? CODE_BOT : cur - 1'b1;
    end

    // R4: an up step never lands below the current code, a down step never above
    always @(posedge clk) begin
        if (rst_n) begin
            if (up) begin
                assert_no_wrap_up_R4: assert (nxt >= cur);
            end else begin
                assert_no_wrap_dn_R4: assert (nxt <= cur);
            end
        end
    end
endmodule

// File: rtl/wsc_settle_timer.sv
module wsc_settle_timer #(
    parameter int SETTLE_CYC = 16,
    localparam int TW = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= TW'(SETTLE_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_reload_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> !busy);
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wsc_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CW         = 8,
    parameter int SETTLE_CYC = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_arm,
    input  logic [CHW-1:0]    arm_chan,
    input  logic              scl_rise,
    input  logic              sda_lvl,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [NCH*CW-1:0] wiper_all,
    output logic              wr_en,
    output logic [CHW-1:0]    wr_chan,
    output logic [CW-1:0]     wr_code,
    output logic              settle_busy
);
    step_state_e    state_q, state_d;
    logic [CHW-1:0] chan_q;
    logic           wr_en_q;
    logic [CW-1:0]  wr_code_q;
    logic [CW-1:0]  cur_code;
    logic [CW-1:0]  nxt_code;
    logic           term;
    logic           step_go;

    assign term    = bus_start | bus_stop;
    assign step_go = (state_q == S_ARMED) && scl_rise && !term && !step_arm;

    wsc_chan_mux #(.NCH(NCH), .CW(CW)) u_mux (
        .codes_flat (wiper_all),
        .sel        (chan_q),
        .code       (cur_code)
    );

    wsc_sat_step #(.CW(CW)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur_code),
        .up    (sda_lvl),
        .nxt   (nxt_code)
    );

    wsc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_en_q),
        .busy  (settle_busy)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm, step, rearm, terminate
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (step_arm) state_d = S_ARMED;
            end
            S_ARMED: begin
                if (term)          state_d = S_IDLE;
                else if (step_arm) state_d = S_ARMED;
                else if (scl_rise) state_d = S_COMMIT;
            end
            S_COMMIT: begin
                if (term) state_d = S_IDLE;
                else      state_d = S_ARMED;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and channel capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q    <= '0;
            wr_en_q   <= 1'b0;
            wr_code_q <= '0;
        end else begin
            if (step_arm) chan_q <= arm_chan;
            wr_en_q <= step_go;
            if (step_go) wr_code_q <= nxt_code;
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_chan = chan_q;
    assign wr_code = wr_code_q;

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |=> !wr_en_q);

    assert_strobe_needs_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !wr_en_q);

    assert_term_ends_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !step_arm) |=> (state_q == S_IDLE && !wr_en_q));

    assert_start_ends_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !step_arm) |=> (state_q == S_IDLE));

    assert_chan_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_arm |=> $stable(chan_q));

    assert_term_beats_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && term) |=> !wr_en_q);
endmodule

// File: tb/wiper_step_ctrl_tb_top.sv
`timescale 1ns/100ps
module wiper_step_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int SETTLE = 5;
    localparam int CHW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_arm = 1'b0;
    logic [CHW-1:0] arm_chan = '0;
    logic scl_rise = 1'b0;
    logic sda_lvl = 1'b0;
    logic bus_start = 1'b0;
    logic bus_stop = 1'b0;
    logic [NCH*CW-1:0] wiper_all;
    logic wr_en;
    logic [CHW-1:0] wr_chan;
    logic [CW-1:0] wr_code;
    logic settle_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    logic [CW-1:0] regs   [NCH];
    logic [CW-1:0] shadow [NCH];

    always #2.5 clk = ~clk;

    wiper_step_ctrl #(.NCH(NCH), .CW(CW), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_arm(step_arm), .arm_chan(arm_chan),
        .scl_rise(scl_rise), .sda_lvl(sda_lvl), .bus_start(bus_start),
        .bus_stop(bus_stop), .wiper_all(wiper_all), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_code(wr_code), .settle_busy(settle_busy)
    );

    // volatile wiper register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            regs[0] <= 8'h10; regs[1] <= 8'h80; regs[2] <= 8'hFE; regs[3] <= 8'h01;
        end else if (wr_en) begin
            regs[wr_chan] <= wr_code;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) wiper_all[i*CW +: CW] = regs[i];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] v, input bit up);
        if (up) return (v == 8'hFF) ? 8'hFF : v + 8'd1;
        else    return (v == 8'h00) ? 8'h00 : v - 8'd1;
    endfunction

    task automatic arm(input int ch);
        @(negedge clk);
        step_arm = 1'b1; arm_chan = CHW'(ch);
        @(negedge clk);
        step_arm = 1'b0;
    endtask

    task automatic term_pulse(input bit is_start);
        @(negedge clk);
        if (is_start) bus_start = 1'b1; else bus_stop = 1'b1;
        @(negedge clk);
        bus_start = 1'b0; bus_stop = 1'b0;
    endtask

    // one step pulse; ends at the sample where settle_busy should first be high
    task automatic step(input bit up, input int ch, input string tag);
        logic [CW-1:0] exp;
        exp = sat_step(shadow[ch], up);
        shadow[ch] = exp;
        @(negedge clk);
        scl_rise = 1'b1; sda_lvl = up;
        @(negedge clk);
        scl_rise = 1'b0;
        chk(wr_en == 1'b1, {tag, " strobe"}, int'(wr_en), 1);
        chk(wr_code == exp, {tag, " code"}, int'(wr_code), int'(exp));
        chk(wr_chan == CHW'(ch), {tag, " chan"}, int'(wr_chan), ch);
        sda_lvl = ~up;
        @(negedge clk);
        chk(wr_en == 1'b0 && settle_busy == 1'b1, {tag, " single strobe/settle"},
            int'({wr_en, settle_busy}), 1);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scl edges that must not write
    task automatic no_step(input int n, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            scl_rise = 1'b1; sda_lvl = i[0];
            @(negedge clk);
            scl_rise = 1'b0;
            if (wr_en) seen++;
            @(negedge clk);
            if (wr_en) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic regs_match(input string tag);
        for (int c = 0; c < NCH; c++)
            chk(regs[c] == shadow[c], tag, int'(regs[c]), int'(shadow[c]));
    endtask

    task automatic t_reset;
        chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);
        chk(settle_busy == 1'b0, "R1 reset settle_busy", int'(settle_busy), 0);
        no_step(2, "R1 idle after reset no strobe");
    endtask

    task automatic t_unarmed;
        no_step(3, "R5 scl edges before arm");
        regs_match("R5 registers untouched");
        // edge coinciding with the arm pulse
        @(negedge clk);
        step_arm = 1'b1; arm_chan = 2'd1; scl_rise = 1'b1; sda_lvl = 1'b1;
        @(negedge clk);
        step_arm = 1'b0; scl_rise = 1'b0;
        chk(wr_en == 1'b0, "R5 edge with arm", int'(wr_en), 0);
        @(negedge clk);
        chk(wr_en == 1'b0, "R5 edge with arm next", int'(wr_en), 0);
        term_pulse(1'b0);
    endtask

    task automatic t_up_down;
        arm(1);
        step(1'b1, 1, "R2 up ch1"); gap(SETTLE + 1);
        step(1'b0, 1, "R3 down ch1"); gap(SETTLE + 1);
        step(1'b0, 1, "R3 down ch1 again"); gap(SETTLE + 1);
        term_pulse(1'b0);
        regs_match("R2 R3 register contents");
    endtask

    task automatic t_saturate;
        arm(2);
        step(1'b1, 2, "R4 FE up"); gap(2);
        step(1'b1, 2, "R4 FF up holds"); gap(2);
        term_pulse(1'b0);
        arm(3);
        step(1'b0, 3, "R4 01 down"); gap(2);
        step(1'b0, 3, "R4 00 down holds"); gap(2);
        term_pulse(1'b0);
        chk(regs[2] == 8'hFF, "R4 top value", int'(regs[2]), 8'hFF);
        chk(regs[3] == 8'h00, "R4 bottom value", int'(regs[3]), 8'h00);
    endtask

    task automatic t_mixed;
        bit seq [9] = '{1, 1, 0, 1, 0, 0, 0, 1, 1};
        arm(0);
        foreach (seq[i]) begin
            step(seq[i], 0, "R8 mixed step");
            gap(1);
        end
        term_pulse(1'b0);
        chk(regs[0] == 8'h11, "R8 mixed final", int'(regs[0]), 8'h11);
    endtask

    task automatic t_stop;
        arm(1);
        step(1'b1, 1, "R6 step before stop"); gap(2);
        term_pulse(1'b0);
        no_step(3, "R6 edges after stop");
        regs_match("R6 registers after stop");
    endtask

    task automatic t_start;
        arm(0);
        term_pulse(1'b1);
        no_step(3, "R7 edges after start");
        regs_match("R7 registers after start");
    endtask

    task automatic t_collide;
        arm(1);
        @(negedge clk);
        scl_rise = 1'b1; sda_lvl = 1'b1; bus_stop = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0; bus_stop = 1'b0;
        chk(wr_en == 1'b0, "R11 edge with stop", int'(wr_en), 0);
        no_step(2, "R11 mode ended by stop");
        arm(1);
        @(negedge clk);
        scl_rise = 1'b1; sda_lvl = 1'b0; bus_start = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0; bus_start = 1'b0;
        chk(wr_en == 1'b0, "R11 edge with start", int'(wr_en), 0);
        no_step(2, "R11 mode ended by start");
        regs_match("R11 registers");
    endtask

    task automatic t_chan_hold;
        arm(1);
        @(negedge clk);
        arm_chan = 2'd3;
        step(1'b1, 1, "R10 channel held");
        gap(2);
        term_pulse(1'b0);
        regs_match("R10 only armed channel written");
    endtask

    task automatic t_settle;
        int c;
        arm(0);
        step(1'b1, 0, "R9 settle step");
        c = 0;
        while (settle_busy && c < 100) begin c++; @(negedge clk); end
        chk(c == SETTLE, "R9 settle length", c, SETTLE);
        step(1'b0, 0, "R9 first of pair");
        gap(2);
        step(1'b1, 0, "R9 restart step");
        c = 0;
        while (settle_busy && c < 100) begin c++; @(negedge clk); end
        chk(c == SETTLE, "R9 restarted length", c, SETTLE);
        term_pulse(1'b0);
    endtask

    initial begin
        shadow[0] = 8'h10; shadow[1] = 8'h80; shadow[2] = 8'hFE; shadow[3] = 8'h01;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_up_down();
        t_saturate();
        t_mixed();
        t_stop();
        t_start();
        t_collide();
        t_chan_hold();
        t_settle();
        regs_match("final register image");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule